// File: doc/BRIEF.md
# Eviction Catch Buffer

This block sits beside a set-associative first-level cache and keeps a handful of blocks that the cache has recently thrown out. Each eviction from the cache is pushed into the buffer with its block address (tag and set index together) and its data. Any free slot can take any block, and all sets of the cache share the slots.

When the cache misses, it presents the block address to the buffer before anything goes to the next level. Every valid slot is compared with that address in the same cycle. On a match the buffer returns the block and raises a hit. The cache then asserts a take strobe, and the slot is emptied at the clock edge that accepts the swap. With no match the buffer raises a miss, and the cache forwards the request downward. When every slot is full, a new eviction overwrites the slot that was filled longest ago. An eviction whose address is presented for lookup in the same cycle is visible to that lookup at once.

Top module: `victim_buffer`

## Requirements
- R1: After reset every slot is empty, so a lookup of any address reports a miss.
- R2: After an eviction is stored, a lookup of the same block address reports a hit and returns the stored data in the same cycle. The whole address is compared, so an address that differs in any single bit misses.
- R3: While `lookValid` is high, exactly one of `lookHit` and `lookMiss` is high, with no clock edge in between. While `lookValid` is low, both are low.
- R4: A lookup that hits while `swapTake` is high empties the matching slot at that clock edge. A later lookup of that address misses, and the other stored blocks stay in place.
- R5: `swapTake` has no effect when `lookValid` is low or when the lookup misses. No stored block is lost.
- R6: The buffer holds up to ENTRIES blocks, with default 8. Blocks from any set of the cache can occupy any slot, and ENTRIES blocks with different addresses are all kept.
- R7: When every slot is valid, a new eviction of a new address replaces the block that was inserted longest ago, in FIFO order.
- R8: While any slot is free, an eviction of a new address goes into a free slot and displaces no stored block.
- R9: When an eviction and a lookup carry the same address in one cycle, the lookup hits and returns the data being inserted. If `swapTake` is also high, no copy of that address remains afterwards.
- R10: An eviction whose address is already held overwrites that slot with the new data and makes it the youngest entry. No second copy is created.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| insValid | input | 1 | Eviction from the cache is present this cycle |
| insAddr | input | ADDR_W | Block address (tag and set index) of the evicted block |
| insData | input | DATA_W | Contents of the evicted block |
| lookValid | input | 1 | Cache miss lookup is present this cycle |
| lookAddr | input | ADDR_W | Block address being looked up |
| swapTake | input | 1 | Cache accepts the returned block; the slot is freed at this edge |
| lookHit | output | 1 | Lookup found the block |
| lookMiss | output | 1 | Lookup did not find the block; forward it to the next level |
| lookData | output | DATA_W | Block contents returned on a hit |

## Verification
The bench builds the buffer with 4 slots, a 6-bit block address and 8-bit data. With a 6-bit address, the bench can probe all 64 addresses after every step and compare each result with a FIFO reference model. Stale copies, lost blocks and address aliasing therefore show up wherever they occur. With only 4 slots, the bench reaches a full buffer within a few evictions. Full-buffer replacement, the refilling of holes left by swaps, same-address refreshes and the same-cycle insert-and-lookup cases all occur many times within a short run.

// File: rtl/victim_buffer_pkg.sv
package victim_buffer_pkg;
  typedef struct packed {
    logic wrEn;
    logic useIns;
  } vbStrobe_t;
endpackage

// File: rtl/victim_buffer_dp.sv
module victim_buffer_dp
  import victim_buffer_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   insAddr,
  input  logic [DATA_W-1:0]   insData,
  input  logic [ADDR_W-1:0]   lookAddr,
  input  vbStrobe_t           strobe,
  input  logic [ENTRIES-1:0]  wrSlot,
  input  logic [ENTRIES-1:0]  clrMask,
  output logic [ENTRIES-1:0]  matchLook,
  output logic [ENTRIES-1:0]  matchIns,
  output logic                sameAddr,
  output logic [ENTRIES-1:0]  validVec,
  output logic [DATA_W-1:0]   lookData
);
  logic [ADDR_W-1:0] addrQ [ENTRIES];
  logic [DATA_W-1:0] dataQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [DATA_W-1:0] storedData;

  assign validVec = validQ;
  assign sameAddr = (insAddr == lookAddr);

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gSlot
      assign matchLook[g] = validQ[g] && (addrQ[g] == lookAddr);
      assign matchIns[g]  = validQ[g] && (addrQ[g] == insAddr);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          validQ[g] <= 1'b0;
        end else if (strobe.wrEn && wrSlot[g]) begin
          validQ[g] <= 1'b1;
        end else if (clrMask[g]) begin
          validQ[g] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (strobe.wrEn && wrSlot[g]) begin
          addrQ[g] <= insAddr;
          dataQ[g] <= insData;
        end
      end
    end
  endgenerate

  always_comb begin
    storedData = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchLook[i]) storedData = storedData | dataQ[i];
    end
  end

  assign lookData = strobe.useIns ? insData : storedData;

  assert_single_match_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchLook));

  assert_taken_slot_freed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|clrMask && !strobe.wrEn) |=> ((validQ & $past(clrMask)) == '0));

  assert_written_slot_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> ((validQ & $past(wrSlot)) == $past(wrSlot)));

  assert_one_loss_per_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> ($countones(validQ) <= $countones($past(validQ))));
endmodule

// File: rtl/victim_buffer_ctrl.sv
module victim_buffer_ctrl
  import victim_buffer_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               insValid,
  input  logic               lookValid,
  input  logic               swapTake,
  input  logic [ENTRIES-1:0] matchLook,
  input  logic [ENTRIES-1:0] matchIns,
  input  logic               sameAddr,
  input  logic [ENTRIES-1:0] validVec,
  output vbStrobe_t          strobe,
  output logic [ENTRIES-1:0] wrSlot,
  output logic [ENTRIES-1:0] clrMask,
  output logic               lookHit,
  output logic               lookMiss
);
  // olderQ[i][j] set: slot i was written before slot j
  logic [ENTRIES-1:0] olderQ [ENTRIES];
  logic [ENTRIES-1:0] isOldest;
  logic [ENTRIES-1:0] freeSlot;
  logic               freeFound;
  logic               bypass;
  logic               take;

  assign bypass   = insValid && lookValid && sameAddr;
  assign lookHit  = lookValid && (bypass || (|matchLook));
  assign lookMiss = lookValid && !lookHit;
  assign take     = swapTake && lookHit;

  assign strobe.useIns = bypass;
  assign strobe.wrEn   = insValid && !(take && bypass);
  assign clrMask       = take ? matchLook : '0;

  always_comb begin
    freeSlot  = '0;
    freeFound = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!validVec[i] && !freeFound) begin
        freeSlot[i] = 1'b1;
        freeFound   = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      isOldest[i] = validVec[i];
      for (int j = 0; j < ENTRIES; j++) begin
        if (j != i && validVec[j] && !olderQ[i][j]) isOldest[i] = 1'b0;
      end
    end
  end

  assign wrSlot = (|matchIns) ? matchIns : (freeFound ? freeSlot : isOldest);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) olderQ[i] <= '0;
    end else if (strobe.wrEn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        for (int j = 0; j < ENTRIES; j++) begin
          if (wrSlot[i])      olderQ[i][j] <= 1'b0;
          else if (wrSlot[j]) olderQ[i][j] <= 1'b1;
        end
      end
    end
  end

  assert_slot_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> $onehot(wrSlot));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !lookValid |-> (!lookHit && !lookMiss));

  assert_ignored_take_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!lookHit || !swapTake) |=> ($countones(validVec) >= $countones($past(validVec))));

  assert_no_evict_when_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !(&validVec) && clrMask == '0) |=>
      ($countones(validVec) >= $countones($past(validVec))));
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
  import victim_buffer_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic [DATA_W-1:0] insData,
  input  logic              lookValid,
  input  logic [ADDR_W-1:0] lookAddr,
  input  logic              swapTake,
  output logic              lookHit,
  output logic              lookMiss,
  output logic [DATA_W-1:0] lookData
);
  vbStrobe_t          strobe;
  logic [ENTRIES-1:0] wrSlot;
  logic [ENTRIES-1:0] clrMask;
  logic [ENTRIES-1:0] matchLook;
  logic [ENTRIES-1:0] matchIns;
  logic [ENTRIES-1:0] validVec;
  logic               sameAddr;

  victim_buffer_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .insValid(insValid), .lookValid(lookValid),
    .swapTake(swapTake), .matchLook(matchLook), .matchIns(matchIns),
    .sameAddr(sameAddr), .validVec(validVec), .strobe(strobe),
    .wrSlot(wrSlot), .clrMask(clrMask), .lookHit(lookHit), .lookMiss(lookMiss)
  );

  victim_buffer_dp #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .insAddr(insAddr), .insData(insData),
    .lookAddr(lookAddr), .strobe(strobe), .wrSlot(wrSlot), .clrMask(clrMask),
    .matchLook(matchLook), .matchIns(matchIns), .sameAddr(sameAddr),
    .validVec(validVec), .lookData(lookData)
  );

  assert_same_cycle_visible_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lookValid && insValid && lookAddr == insAddr) |-> (lookHit && lookData == insData));
endmodule

// File: tb/victim_buffer_test.sv
module victim_buffer_test;
  localparam int N  = 4;
  localparam int AW = 6;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insValid = 1'b0;
  logic [AW-1:0] insAddr = '0;
  logic [DW-1:0] insData = '0;
  logic lookValid = 1'b0;
  logic [AW-1:0] lookAddr = '0;
  logic swapTake = 1'b0;
  logic lookHit, lookMiss;
  logic [DW-1:0] lookData;

  victim_buffer #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insAddr(insAddr),
    .insData(insData), .lookValid(lookValid), .lookAddr(lookAddr),
    .swapTake(swapTake), .lookHit(lookHit), .lookMiss(lookMiss),
    .lookData(lookData)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int seq = 0;
  logic [AW-1:0] qA [N];
  logic [DW-1:0] qD [N];
  int qLen = 0;

  function automatic int mFind(logic [AW-1:0] a);
    for (int i = 0; i < qLen; i++) if (qA[i] == a) return i;
    return -1;
  endfunction

  function automatic void mRemove(int k);
    for (int i = k; i < qLen - 1; i++) begin
      qA[i] = qA[i+1];
      qD[i] = qD[i+1];
    end
    qLen--;
  endfunction

  function automatic void mInsert(logic [AW-1:0] a, logic [DW-1:0] d);
    int k = mFind(a);
    if (k >= 0) mRemove(k);
    else if (qLen == N) mRemove(0);
    qA[qLen] = a;
    qD[qLen] = d;
    qLen++;
  endfunction

  function automatic logic [DW-1:0] mkData(logic [AW-1:0] a);
    seq++;
    return DW'(a) ^ DW'(seq * 37);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Lookup without take; compare hit/miss/data with the FIFO model
  task automatic probe(logic [AW-1:0] a, string req);
    int k;
    bit expHit;
    logic [DW-1:0] expD;
    @(negedge clk);
    lookAddr = a;
    lookValid = 1'b1;
    #1;
    k = mFind(a);
    expHit = (k >= 0);
    expD = expHit ? qD[k] : lookData;
    check(lookHit == expHit && lookMiss == !expHit && lookData == expD, req,
          {14'd0, a, lookHit, lookMiss, lookData}, {14'd0, a, expHit, !expHit, expD});
    lookValid = 1'b0;
  endtask

  task automatic sweep(string req);
    for (int a = 0; a < (1 << AW); a++) probe(AW'(a), req);
  endtask

  task automatic doInsert(logic [AW-1:0] a);
    logic [DW-1:0] d = mkData(a);
    @(negedge clk);
    insValid = 1'b1;
    insAddr = a;
    insData = d;
    @(negedge clk);
    insValid = 1'b0;
    mInsert(a, d);
  endtask

  task automatic doTake(logic [AW-1:0] a, string req);
    bit expHit = (mFind(a) >= 0);
    @(negedge clk);
    lookValid = 1'b1;
    lookAddr = a;
    swapTake = 1'b1;
    #1;
    check(lookHit == expHit, req, {31'd0, lookHit}, {31'd0, expHit});
    @(negedge clk);
    lookValid = 1'b0;
    swapTake = 1'b0;
    if (expHit) mRemove(mFind(a));
  endtask

  task automatic doBypass(logic [AW-1:0] a, bit tk, string req);
    logic [DW-1:0] d = mkData(a);
    @(negedge clk);
    insValid = 1'b1;
    insAddr = a;
    insData = d;
    lookValid = 1'b1;
    lookAddr = a;
    swapTake = tk;
    #1;
    check(lookHit && !lookMiss && lookData == d, req,
          {22'd0, lookHit, lookMiss, lookData}, {22'd0, 1'b1, 1'b0, d});
    @(negedge clk);
    insValid = 1'b0;
    lookValid = 1'b0;
    swapTake = 1'b0;
    if (tk) begin
      if (mFind(a) >= 0) mRemove(mFind(a));
    end else begin
      mInsert(a, d);
    end
  endtask

  bit finished = 1'b0;

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int x = 7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 and R3: empty after reset; idle outputs low
    #1;
    check(!lookHit && !lookMiss, "R3 idle", {30'd0, lookHit, lookMiss}, 32'd0);
    sweep("R1");

    // R2 and R6: fill every slot; full-address compare over all 64 addresses
    doInsert(6'h05);
    doInsert(6'h2A);
    doInsert(6'h11);
    doInsert(6'h3F);
    sweep("R6");

    // R7: fifth new block evicts the oldest (0x05)
    doInsert(6'h04);
    sweep("R7");

    // R4: take frees one slot only
    doTake(6'h11, "R4");
    sweep("R4");

    // R5: take without lookup, take on a miss
    @(negedge clk);
    swapTake = 1'b1;
    @(negedge clk);
    lookValid = 1'b1;
    lookAddr = 6'h05;
    @(negedge clk);
    lookValid = 1'b0;
    swapTake = 1'b0;
    sweep("R5");

    // R8: free slot used, nothing displaced
    doInsert(6'h20);
    sweep("R8");

    // R10: refresh existing address, then force evictions to see order
    doInsert(6'h2A);
    sweep("R10");
    doInsert(6'h01);
    doInsert(6'h02);
    sweep("R10");

    // R9: same-cycle insert and lookup, with and without take
    doBypass(6'h33, 1'b0, "R9");
    sweep("R9");
    doBypass(6'h2A, 1'b1, "R9");
    doBypass(6'h15, 1'b1, "R9");
    sweep("R9");

    // R2 and R7: mixed traffic
    for (int it = 0; it < 30; it++) begin
      x = x * 1103515245 + 12345;
      doInsert(AW'(x >>> 9));
      if ((it % 3) == 2 && qLen > 0) doTake(qA[((x >>> 4) & 32'h7fff) % qLen], "R4");
      if ((it % 5) == 4) sweep("R2");
    end
    sweep("R7");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule